// File: doc/BRIEF.md
# Byte-Lane Pseudo-SRAM Access Controller

This block sits between a simple synchronous host port and a 16-bit asynchronous pseudo-SRAM that has one active-low select per byte lane. The host raises a request with an address, a direction, write data and a two-bit byte enable. It holds the request until the controller returns a single-cycle acknowledge. For each request the controller produces exactly one pin-level memory cycle. Every phase of that cycle has a length set in system clocks by a parameter.

The memory refreshes itself internally, so an access cycle has a floor and a ceiling on its length. The controller opens chip select for one fixed, parameterized window and always closes it at the end of each access. Address and write data are set up before chip select falls and stay steady while it is low. The bus drive is released well before output enable is lowered on a read. Power-up, standby and burst handling belong to other logic.

Top module: `bytelane_psram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, write enable, output enable and both byte selects are high, the data drive enable is low and the acknowledge is low.
- R2: Each request, held until acknowledged, yields exactly one acknowledge, one cycle wide. No acknowledge appears without a request.
- R3: Byte-enable bit 0 drives the lower select low and controls data bits 7:0. Bit 1 drives the upper select low and controls bits 15:8. A write changes only the enabled lanes of the addressed word.
- R4: A write request with byte enable 00 holds both byte selects high for the whole cycle. The word is left unchanged and the request is still acknowledged.
- R5: Write enable is low only while chip select is low. The address does not change while chip select is low.
- R6: During a read, write enable stays high. Output enable is low only while the data drive enable is low.
- R7: Read data is sampled ACCESS_CYC clocks after chip select falls and is presented on the host read data port in the acknowledge cycle. Lanes whose enable bit is 0 read as zero.
- R8: Chip select stays low for exactly ACCESS_CYC clocks on a read and WRPULSE_CYC clocks on a write. This keeps every cycle far below the 10 µs refresh ceiling.
- R9: On a write, the data drive enable is high with stable data from the setup phase until one clock after write enable and chip select rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with the acknowledge |
| mem_addr | output | 20 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus buffer |
| mem_dq_i | input | 16 | Data received from the memory |

## Verification
The assertions assume the host keeps each request steady from the time it is raised until the acknowledge. They also assume SETUP_CYC, ACCESS_CYC, WRPULSE_CYC and RECOV_CYC are all at least 1. The stimulus waits for the acknowledge and changes nothing before it. It then drops the request in the next cycle, during the recovery phase, so a request is never taken twice. Random addresses come from a small pool so reads return earlier writes. The memory model only supplies valid read data after chip select has been low for at least 85 ns of clocks. A read sampled too early therefore returns a marker value, not the stored word.

// File: rtl/blp_pkg.sv
package blp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_FINISH,
    ST_RECOV
  } blp_state_e;
endpackage

// File: rtl/blp_phase_timer.sv
module blp_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val - CNT_W'(1);
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/blp_pin_drv.sv
module blp_pin_drv
  import blp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  blp_state_e        state_nxt,
  input  logic              wr_nxt,
  input  logic [LANES-1:0]  be_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [DATA_W-1:0] wdata_nxt,
  output logic [ADDR_W-1:0] pin_addr,
  output logic              pin_cs_n,
  output logic              pin_we_n,
  output logic              pin_oe_n,
  output logic [LANES-1:0]  pin_lane_n,
  output logic [DATA_W-1:0] pin_dq_o,
  output logic              pin_dq_oe
);
  logic strobe;
  assign strobe = (state_nxt == ST_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_addr  <= '0;
      pin_cs_n  <= 1'b1;
      pin_we_n  <= 1'b1;
      pin_oe_n  <= 1'b1;
      pin_dq_o  <= '0;
      pin_dq_oe <= 1'b0;
    end else begin
      pin_addr  <= addr_nxt;
      pin_cs_n  <= !strobe;
      pin_we_n  <= !(strobe && wr_nxt);
      pin_oe_n  <= !(strobe && !wr_nxt);
      pin_dq_o  <= wdata_nxt;
      pin_dq_oe <= wr_nxt && (state_nxt == ST_SETUP || strobe || state_nxt == ST_FINISH);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) pin_lane_n[g] <= 1'b1;
      else     pin_lane_n[g] <= !(strobe && be_nxt[g]);
    end
  end
endmodule

// File: rtl/bytelane_psram_ctrl.sv
module bytelane_psram_ctrl
  import blp_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int SETUP_CYC   = 1,
  parameter int ACCESS_CYC  = 6,
  parameter int WRPULSE_CYC = 5,
  parameter int RECOV_CYC   = 2,
  localparam int LANES      = DATA_W / 8,
  localparam int STROBE_MAX = (ACCESS_CYC > WRPULSE_CYC) ? ACCESS_CYC : WRPULSE_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  blp_state_e        state, state_nxt;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              cur_wr, wr_nxt;
  logic [ADDR_W-1:0] cur_addr, addr_nxt;
  logic [DATA_W-1:0] cur_wdata, wdata_nxt;
  logic [LANES-1:0]  cur_be, be_nxt;
  logic [LANES-1:0]  lane_n;
  logic              take;
  logic              sample;

  assign take      = (state == ST_IDLE) && req_valid;
  assign wr_nxt    = take ? req_write : cur_wr;
  assign addr_nxt  = take ? req_addr  : cur_addr;
  assign wdata_nxt = take ? req_wdata : cur_wdata;
  assign be_nxt    = take ? req_be    : cur_be;
  assign sample    = (state == ST_STROBE) && tmr_done && !cur_wr;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        state_nxt = ST_SETUP;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(SETUP_CYC);
      end
      ST_SETUP: if (tmr_done) begin
        state_nxt = ST_STROBE;
        tmr_load  = 1'b1;
        tmr_val   = cur_wr ? CNT_W'(WRPULSE_CYC) : CNT_W'(ACCESS_CYC);
      end
      ST_STROBE: if (tmr_done) state_nxt = ST_FINISH;
      ST_FINISH: begin
        state_nxt = ST_RECOV;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(RECOV_CYC);
      end
      ST_RECOV: if (tmr_done) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ack   <= 1'b0;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_be    <= '0;
    end else begin
      state     <= state_nxt;
      req_ack   <= (state_nxt == ST_FINISH);
      cur_wr    <= wr_nxt;
      cur_addr  <= addr_nxt;
      cur_wdata <= wdata_nxt;
      cur_be    <= be_nxt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)         rsp_rdata[g*8 +: 8] <= '0;
      else if (sample) rsp_rdata[g*8 +: 8] <= cur_be[g] ? mem_dq_i[g*8 +: 8] : 8'h00;
    end
  end

  blp_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  blp_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .state_nxt  (state_nxt),
    .wr_nxt     (wr_nxt),
    .be_nxt     (be_nxt),
    .addr_nxt   (addr_nxt),
    .wdata_nxt  (wdata_nxt),
    .pin_addr   (mem_addr),
    .pin_cs_n   (mem_cs_n),
    .pin_we_n   (mem_we_n),
    .pin_oe_n   (mem_oe_n),
    .pin_lane_n (lane_n),
    .pin_dq_o   (mem_dq_o),
    .pin_dq_oe  (mem_dq_oe)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[LANES-1];

  // Run length of the low phase of chip select, checked against the window.
  logic [CNT_W:0] cs_run;
  always_ff @(posedge clk) begin
    if (rst)            cs_run <= '0;
    else if (!mem_cs_n) cs_run <= cs_run + 1'b1;
    else                cs_run <= '0;
  end

  AST_ACK_PULSE:    assert property (@(posedge clk) disable iff (rst) req_ack |=> !req_ack);                       // R2
  AST_WE_IN_CS:     assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> !mem_cs_n);                    // R5
  AST_ADDR_HOLD:    assert property (@(posedge clk) disable iff (rst) (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5
  AST_NO_CONTEND:   assert property (@(posedge clk) disable iff (rst) !mem_oe_n |-> !mem_dq_oe);                   // R6
  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst) !mem_oe_n |-> mem_we_n);                     // R6
  AST_CS_WINDOW:    assert property (@(posedge clk) disable iff (rst) cs_run <= (CNT_W+1)'(STROBE_MAX));           // R8
  AST_WDATA_HOLD:   assert property (@(posedge clk) disable iff (rst) (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R9
  AST_WE_DATA:      assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> mem_dq_oe);                    // R9
endmodule

// File: tb/sim_bytelane_psram_ctrl.sv
module sim_bytelane_psram_ctrl;
  localparam int ACC = 6;
  localparam int WRP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hBAD0;

  int checks = 0, fails = 0, viol = 0, ack_cnt = 0, last_len = 0, low_cnt = 0;
  logic [15:0] mdl [logic [19:0]];
  logic [15:0] refm [logic [19:0]];
  logic [19:0] pool [16];

  always #10 clk = ~clk;

  bytelane_psram_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  function automatic logic [15:0] init_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h3C5};
  endfunction

  function automatic logic [15:0] mdl_rd(input logic [19:0] a);
    return mdl.exists(a) ? mdl[a] : init_word(a);
  endfunction

  function automatic logic [15:0] ref_rd(input logic [19:0] a);
    return refm.exists(a) ? refm[a] : init_word(a);
  endfunction

  function automatic logic [15:0] exp_read(input logic [19:0] a, input logic [1:0] be);
    logic [15:0] w = ref_rd(a);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  // Memory model and pin monitors, evaluated away from the active edge
  logic        p_act = 1'b0, p_lb = 1'b1, p_ub = 1'b1, p_oe = 1'b0, p_cs_low = 1'b0;
  logic [15:0] p_dq = '0;
  logic [19:0] p_addr = '0;
  always @(negedge clk) begin
    logic act;
    if (!rst) begin
      if (req_ack) ack_cnt++;
      if (!mem_cs_n) low_cnt++;
      else begin
        if (low_cnt != 0) last_len = low_cnt;
        low_cnt = 0;
      end
      act = !mem_cs_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);
      if (p_act && !act) begin
        if (!p_oe) begin viol++; $display("FAIL R9: write ended with drive enable 0, expected 1"); end
        mdl[p_addr] = {p_ub ? mdl_rd(p_addr)[15:8] : p_dq[15:8], p_lb ? mdl_rd(p_addr)[7:0] : p_dq[7:0]};
      end
      if (!mem_we_n && mem_cs_n) begin viol++; $display("FAIL R5: write enable low with chip select high"); end
      if (p_cs_low && !mem_cs_n && mem_addr != p_addr) begin viol++; $display("FAIL R5: address %h changed from %h under chip select", mem_addr, p_addr); end
      if (!mem_oe_n && mem_dq_oe) begin viol++; $display("FAIL R6: output enable low while bus driven"); end
      if (!mem_oe_n && !mem_we_n) begin viol++; $display("FAIL R6: write enable low during read"); end
      mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n && low_cnt >= 5) ? mdl_rd(mem_addr) : 16'hBAD0;
      p_act = act; p_lb = mem_lb_n; p_ub = mem_ub_n; p_oe = mem_dq_oe;
      p_dq = mem_dq_o; p_addr = mem_addr; p_cs_low = !mem_cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] exp;
    int n;
    exp = exp_read(a, be);
    @(negedge clk);
    ack_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ack && n < 60);
    check(req_ack, "R2 ack arrives", {31'd0, req_ack}, 32'd1);
    if (!wr) check(rsp_rdata == exp, (be == 2'b11) ? "R7 read word" : "R3 lane read", {16'd0, rsp_rdata}, {16'd0, exp});
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(ack_cnt == 1, "R2 one ack per request", ack_cnt, 32'd1);
    check(last_len == (wr ? WRP : ACC), "R8 chip select window", last_len, wr ? WRP : ACC);
    if (wr) refm[a] = merge(ref_rd(a), d, be);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: pins idle during reset
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ack} == 7'b1111100,
          "R1 reset pins", {25'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ack}, 32'h7C);
    rst = 1'b0;
    @(negedge clk);
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ack} == 7'b1111100,
          "R1 after reset", {25'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ack}, 32'h7C);
    repeat (4) @(negedge clk);
    check(ack_cnt == 0, "R2 no ack without request", ack_cnt, 32'd0);

    // Directed corners
    access(1'b0, 20'h00010, 16'h0, 2'b11);            // R7 unwritten word
    access(1'b1, 20'h00010, 16'h1234, 2'b11);
    access(1'b0, 20'h00010, 16'h0, 2'b11);            // R7
    access(1'b1, 20'h00010, 16'hAB99, 2'b01);         // R3 lower only
    access(1'b0, 20'h00010, 16'h0, 2'b11);
    access(1'b1, 20'h00010, 16'hCD77, 2'b10);         // R3 upper only
    access(1'b0, 20'h00010, 16'h0, 2'b11);
    access(1'b1, 20'h00010, 16'hFFFF, 2'b00);         // R4 abort
    access(1'b0, 20'h00010, 16'h0, 2'b11);            // R4 unchanged
    access(1'b0, 20'h00010, 16'h0, 2'b01);            // R7 upper lane zero
    access(1'b0, 20'h00010, 16'h0, 2'b10);            // R7 lower lane zero
    access(1'b0, 20'h00010, 16'h0, 2'b00);            // R7 both zero
    access(1'b1, 20'hFFFFF, 16'h5AA5, 2'b11);         // top address
    access(1'b0, 20'hFFFFF, 16'h0, 2'b11);
    access(1'b0, 20'h00000, 16'h0, 2'b11);

    // Random mix over a small pool of addresses
    for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
    for (int i = 0; i < 300; i++) begin
      access(1'($urandom), pool[$urandom % 16], 16'($urandom), 2'($urandom));
    end

    check(viol == 0, "R5 R6 R9 pin monitors", viol, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule